// File: doc/BRIEF.md
# DMA Channel Register File

This block is the software-visible register file of a multichannel DMA engine. It sits on a simple 32-bit register bus that takes a request and write-enable in the same cycle and returns read data combinationally. It holds the engine-wide burst controls and three split-half registers for completion flags with their enables, error flags with their error types, and channel freeze with channel reset requests. It also holds a window of per-channel registers at a fixed stride.

Each of the four global registers has three addresses. The base address overwrites the register, base+0x4 sets the bits written as 1, and base+0x8 clears the bits written as 1. Channel engines report completion, termination and bus-error events as one-cycle pulses. The block turns these into sticky flags, a level interrupt per channel and a qualified error per channel. It takes channel-reset acknowledges and semaphore decrements from the engines. It drives freeze, reset-request, runnable and next-command outputs back to them.

Top module: `dma_csr_top`

## Requirements
- R1: After reset every stored register reads 0, and irq_o, err_o, freeze_o, chan_rst_o, run_o and both burst outputs are 0.
- R2: Register 0x000 stores only bit 28 (burst_en_o) and bit 29 (burst8_en_o). Every other bit reads 0 whatever was written.
- R3: Register 0x010 holds per-channel completion flags in bits 15:0 and interrupt enables in bits 31:16. A pulse on cmplt_evt_i[n] sets bit n and the bit stays set.
- R4: For registers 0x000, 0x010, 0x020 and 0x030, a write at the base address replaces the value. A write at +0x4 ORs the data in, and a write at +0x8 clears the bits written as 1 and leaves the other bits as they were.
- R5: Register 0x020 holds error flags in bits 15:0 and error types in bits 31:16. A termination pulse sets only the low bit of the channel. A bus-error pulse sets both the low bit and the high bit.
- R6: err_o[n] is high when the error flag of channel n is set and either its type bit is set or its completion flag is clear. A termination alongside completion is therefore not an error.
- R7: irq_o[n] is high when completion flag n and enable n are both set, or when error flag n is set.
- R8: Bits 15:0 of register 0x030 drive freeze_o. Writing 1 to a channel bit at 0x034 freezes that channel, and writing 1 at 0x038 unfreezes it.
- R9: Bits 31:16 of register 0x030 drive chan_rst_o. A request bit stays set until rst_ack_i of that channel pulses, and then clears. An acknowledge wins over a write in the same cycle.
- R10: The next-command register of channel n sits at 0x110+n*0x70. It reads back what was written and drives the channel's slice of nxt_cmd_o. Writes to other channels leave it unchanged.
- R11: The semaphore of channel n sits at 0x140+n*0x70. A write adds the low 8 data bits to it, and a sema_dec_i pulse subtracts 1 unless the count is 0. A write and a decrement in the same cycle combine. run_o[n] is high while the count is non-zero.
- R12: The buffer address at 0x130+n*0x70 reads bar_i of the channel. The debug register at 0x150+n*0x70 reads the channel's dbg_state_i nibble in bits 3:0. Writes to either register have no effect.
- R13: A completion or error event in the same cycle as a clear-alias write to that bit leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the current address |
| cmplt_evt_i | input | 16 | Per-channel completion pulse |
| term_evt_i | input | 16 | Per-channel termination pulse |
| buserr_evt_i | input | 16 | Per-channel bus-error pulse |
| rst_ack_i | input | 16 | Per-channel reset acknowledge |
| sema_dec_i | input | 16 | Per-channel semaphore decrement pulse |
| bar_i | input | 512 | Per-channel current buffer address, 32 bits each |
| dbg_state_i | input | 64 | Per-channel engine state, 4 bits each |
| irq_o | output | 16 | Per-channel interrupt |
| err_o | output | 16 | Per-channel qualified error |
| freeze_o | output | 16 | Per-channel freeze |
| chan_rst_o | output | 16 | Per-channel reset request |
| run_o | output | 16 | Per-channel semaphore non-zero |
| nxt_cmd_o | output | 512 | Per-channel next-command address |
| burst_en_o | output | 1 | Burst enable |
| burst8_en_o | output | 1 | 8-beat burst enable |

## Verification
The bench clears one completion flag through the clear alias while a neighbouring flag is set. A decode that overwrote instead of masking would lose the neighbour. It raises termination and completion together and expects err_o low while irq_o is high. A design that did not qualify the error would flag a false fault. It fires a completion event in the same cycle as a clear of that bit, and it pulses a reset acknowledge against a pending request. A wrong priority would drop the event or leave the channel held in reset. It also decrements an empty semaphore and writes to read-only windows. A design without the floor would wrap the count to 255 and raise run_o, and a design that ignored the read-only rule would replace the live inputs with stale data.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int HALF      = 16;
  localparam int CH_STRIDE = 'h70;
  localparam int OFF_NXT   = 'h110;
  localparam int OFF_BAR   = 'h130;
  localparam int OFF_SEMA  = 'h140;
  localparam int OFF_DBG   = 'h150;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_SET = 2'd1,
    OP_CLR = 2'd2,
    OP_NOP = 2'd3
  } alias_op_e;

  function automatic logic [31:0] alias_apply(logic [31:0] cur, alias_op_e op, logic [31:0] d);
    case (op)
      OP_WR:   return d;
      OP_SET:  return cur | d;
      OP_CLR:  return cur & ~d;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/dma_csr_gbl.sv
module dma_csr_gbl
  import dma_csr_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic           rd_i,
  input  logic [1:0]     sel_i,
  input  logic [1:0]     op_i,
  input  logic [31:0]    wdata_i,
  input  logic [NCH-1:0] cmplt_evt_i,
  input  logic [NCH-1:0] term_evt_i,
  input  logic [NCH-1:0] buserr_evt_i,
  input  logic [NCH-1:0] rst_ack_i,
  output logic [31:0]    rd_o,
  output logic [NCH-1:0] irq_o,
  output logic [NCH-1:0] err_o,
  output logic [NCH-1:0] freeze_o,
  output logic [NCH-1:0] chan_rst_o,
  output logic           burst_en_o,
  output logic           burst8_en_o
);
  logic [1:0]     bst_q, bst_d;
  logic [NCH-1:0] cmp_q, en_q, elo_q, ehi_q, frz_q, rst_q;
  logic [NCH-1:0] cmp_d, en_d, elo_d, ehi_d, frz_d, rst_d;
  logic [31:0]    cur0, cur1, cur2, cur3, nw0, nw1, nw2, nw3;
  alias_op_e      op;

  assign op = alias_op_e'(op_i);

  always_comb begin
    cur0 = '0; cur0[29:28] = bst_q;
    cur1 = '0; cur1[NCH-1:0] = cmp_q; cur1[HALF +: NCH] = en_q;
    cur2 = '0; cur2[NCH-1:0] = elo_q; cur2[HALF +: NCH] = ehi_q;
    cur3 = '0; cur3[NCH-1:0] = frz_q; cur3[HALF +: NCH] = rst_q;
    nw0 = (wr_i && sel_i == 2'd0) ? alias_apply(cur0, op, wdata_i) : cur0;
    nw1 = (wr_i && sel_i == 2'd1) ? alias_apply(cur1, op, wdata_i) : cur1;
    nw2 = (wr_i && sel_i == 2'd2) ? alias_apply(cur2, op, wdata_i) : cur2;
    nw3 = (wr_i && sel_i == 2'd3) ? alias_apply(cur3, op, wdata_i) : cur3;
    bst_d = nw0[29:28];
    // events take priority over clear writes
    cmp_d = nw1[NCH-1:0] | cmplt_evt_i;
    en_d  = nw1[HALF +: NCH];
    elo_d = nw2[NCH-1:0] | term_evt_i | buserr_evt_i;
    ehi_d = nw2[HALF +: NCH] | buserr_evt_i;
    frz_d = nw3[NCH-1:0];
    rst_d = nw3[HALF +: NCH] & ~rst_ack_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bst_q <= '0; cmp_q <= '0; en_q <= '0;
      elo_q <= '0; ehi_q <= '0; frz_q <= '0; rst_q <= '0;
    end else begin
      bst_q <= bst_d; cmp_q <= cmp_d; en_q <= en_d;
      elo_q <= elo_d; ehi_q <= ehi_d; frz_q <= frz_d; rst_q <= rst_d;
    end
  end

  always_comb begin
    rd_o = '0;
    if (rd_i) begin
      case (sel_i)
        2'd0:    rd_o = cur0;
        2'd1:    rd_o = cur1;
        2'd2:    rd_o = cur2;
        default: rd_o = cur3;
      endcase
    end
  end

  assign irq_o       = (cmp_q & en_q) | elo_q;
  assign err_o       = elo_q & (ehi_q | ~cmp_q);
  assign freeze_o    = frz_q;
  assign chan_rst_o  = rst_q;
  assign burst_en_o  = bst_q[0];
  assign burst8_en_o = bst_q[1];

  p_cmplt_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |cmplt_evt_i |=> ((cmp_q & $past(cmplt_evt_i)) == $past(cmplt_evt_i)));
  p_buserr_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |buserr_evt_i |=> ((elo_q & ehi_q & $past(buserr_evt_i)) == $past(buserr_evt_i)));
  p_ack_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |rst_ack_i |=> ((chan_rst_o & $past(rst_ack_i)) == '0));
  p_freeze_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && sel_i == 2'd3) |=> $stable(freeze_o));
endmodule

// File: rtl/dma_csr_chan.sv
module dma_csr_chan
  import dma_csr_pkg::*;
#(
  parameter int AW = 12,
  parameter int SW = 8,
  parameter int CH = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  input  logic [31:0]   bar_i,
  input  logic [3:0]    dbg_i,
  input  logic          dec_i,
  output logic [31:0]   nxt_o,
  output logic          run_o,
  output logic [31:0]   rd_o
);
  localparam logic [AW-1:0] A_NXT  = AW'(OFF_NXT  + CH * CH_STRIDE);
  localparam logic [AW-1:0] A_BAR  = AW'(OFF_BAR  + CH * CH_STRIDE);
  localparam logic [AW-1:0] A_SEMA = AW'(OFF_SEMA + CH * CH_STRIDE);
  localparam logic [AW-1:0] A_DBG  = AW'(OFF_DBG  + CH * CH_STRIDE);

  logic [31:0]   nxt_q;
  logic [SW-1:0] sem_q, sem_d;
  logic          hit_nxt, hit_bar, hit_sem, hit_dbg, wr_nxt, wr_sem, dec_ok;

  assign hit_nxt = req_i && addr_i == A_NXT;
  assign hit_bar = req_i && addr_i == A_BAR;
  assign hit_sem = req_i && addr_i == A_SEMA;
  assign hit_dbg = req_i && addr_i == A_DBG;
  assign wr_nxt  = hit_nxt && we_i;
  assign wr_sem  = hit_sem && we_i;
  assign dec_ok  = dec_i && sem_q != '0;

  always_comb begin
    sem_d = sem_q;
    if (wr_sem) sem_d = sem_d + wdata_i[SW-1:0];
    if (dec_ok) sem_d = sem_d - SW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_q <= '0;
      sem_q <= '0;
    end else begin
      if (wr_nxt) nxt_q <= wdata_i;
      sem_q <= sem_d;
    end
  end

  always_comb begin
    rd_o = '0;
    if (hit_nxt) rd_o = nxt_q;
    if (hit_bar) rd_o = bar_i;
    if (hit_sem) rd_o[SW-1:0] = sem_q;
    if (hit_dbg) rd_o[3:0] = dbg_i;
  end

  assign nxt_o = nxt_q;
  assign run_o = sem_q != '0;

  p_nxt_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_nxt |=> $stable(nxt_o));
  p_sema_dec_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !wr_sem && sem_q != '0) |=> (sem_q == $past(sem_q) - SW'(1)));
  p_sema_floor_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !wr_sem && sem_q == '0) |=> !run_o);
endmodule

// File: rtl/dma_csr_top.sv
module dma_csr_top
  import dma_csr_pkg::*;
#(
  parameter int NCH = 16,
  parameter int AW  = 12,
  parameter int SW  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NCH-1:0]    cmplt_evt_i,
  input  logic [NCH-1:0]    term_evt_i,
  input  logic [NCH-1:0]    buserr_evt_i,
  input  logic [NCH-1:0]    rst_ack_i,
  input  logic [NCH-1:0]    sema_dec_i,
  input  logic [NCH*32-1:0] bar_i,
  input  logic [NCH*4-1:0]  dbg_state_i,
  output logic [NCH-1:0]    irq_o,
  output logic [NCH-1:0]    err_o,
  output logic [NCH-1:0]    freeze_o,
  output logic [NCH-1:0]    chan_rst_o,
  output logic [NCH-1:0]    run_o,
  output logic [NCH*32-1:0] nxt_cmd_o,
  output logic              burst_en_o,
  output logic              burst8_en_o
);
  logic        gbl_hit;
  logic [31:0] gbl_rd;
  logic [31:0] ch_rd [NCH];

  assign gbl_hit = req_i && addr_i[AW-1:6] == '0;

  dma_csr_gbl #(.NCH(NCH)) u_gbl (
    .clk_i, .rst_ni,
    .wr_i        (gbl_hit && we_i),
    .rd_i        (gbl_hit),
    .sel_i       (addr_i[5:4]),
    .op_i        (addr_i[3:2]),
    .wdata_i,
    .cmplt_evt_i, .term_evt_i, .buserr_evt_i, .rst_ack_i,
    .rd_o        (gbl_rd),
    .irq_o, .err_o, .freeze_o, .chan_rst_o, .burst_en_o, .burst8_en_o
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dma_csr_chan #(.AW(AW), .SW(SW), .CH(c)) u_ch (
      .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
      .bar_i (bar_i[c*32 +: 32]),
      .dbg_i (dbg_state_i[c*4 +: 4]),
      .dec_i (sema_dec_i[c]),
      .nxt_o (nxt_cmd_o[c*32 +: 32]),
      .run_o (run_o[c]),
      .rd_o  (ch_rd[c])
    );
  end

  always_comb begin
    rdata_o = gbl_rd;
    for (int c = 0; c < NCH; c++) rdata_o = rdata_o | ch_rd[c];
  end
endmodule

// File: tb/sim_dma_csr_top.sv
`timescale 1ns/1ps
module sim_dma_csr_top;
  localparam int NCH = 16;
  logic clk = 0, rst_n = 0;
  logic req = 0, we = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NCH-1:0] cmplt = '0, term = '0, buserr = '0, ack = '0, dec = '0;
  logic [NCH*32-1:0] bar = '0, nxt;
  logic [NCH*4-1:0] dbg = '0;
  logic [NCH-1:0] irq, err, frz, crst, run;
  logic b_en, b8_en;
  int total = 0, bad = 0;

  typedef struct { logic [31:0] exp; string tag; } exp_t;
  exp_t q[$];
  logic mon_vld = 0;

  always #2.5 clk = ~clk;

  dma_csr_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cmplt_evt_i(cmplt), .term_evt_i(term),
    .buserr_evt_i(buserr), .rst_ack_i(ack), .sema_dec_i(dec), .bar_i(bar),
    .dbg_state_i(dbg), .irq_o(irq), .err_o(err), .freeze_o(frz),
    .chan_rst_o(crst), .run_o(run), .nxt_cmd_o(nxt),
    .burst_en_o(b_en), .burst8_en_o(b8_en)
  );

  // monitor: compares read data against queued expectations
  always @(posedge clk) begin
    #1;
    if (mon_vld && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (rdata !== e.exp) begin
        bad++;
        $display("FAIL %s: got %h exp %h", e.tag, rdata, e.exp);
      end
    end
  end

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); req = 1; we = 0; addr = a; mon_vld = 1;
    q.push_back('{exp: exp, tag: tag});
    @(negedge clk); req = 0; mon_vld = 0;
  endtask

  task automatic pulse(ref logic [NCH-1:0] v, input logic [NCH-1:0] m);
    @(negedge clk); v = m;
    @(negedge clk); v = '0;
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: got timeout exp finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bar[3*32 +: 32] = 32'h8000_1234;
    dbg[3*4 +: 4]   = 4'h8;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(12'h000, 32'h0, "R1 ctrl0");
    rd(12'h010, 32'h0, "R1 ctrl1");
    rd(12'h030, 32'h0, "R1 chctrl");
    @(negedge clk);
    chk({16'h0, irq}, 32'h0, "R1 irq");
    chk({16'h0, run}, 32'h0, "R1 run");

    // R2 burst bits
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, 32'h3000_0000, "R2 only bits 29:28");
    chk({30'h0, b8_en, b_en}, 32'h3, "R2 burst outputs");

    // R3 / R7 completion and enable
    wr(12'h014, 32'h0001_0000);
    pulse(cmplt, 16'h0001);
    rd(12'h010, 32'h0001_0001, "R3 ch0 flag");
    @(negedge clk);
    chk({31'h0, irq[0]}, 32'h1, "R7 irq enabled ch0");
    pulse(cmplt, 16'h0002);
    @(negedge clk);
    chk({31'h0, irq[1]}, 32'h0, "R7 irq masked ch1");
    // R4 clear alias
    wr(12'h018, 32'h0000_0001);
    rd(12'h010, 32'h0001_0002, "R4 clear ch0 only");

    // R5 / R6 errors
    pulse(term, 16'h0004);
    rd(12'h020, 32'h0000_0004, "R5 termination");
    pulse(buserr, 16'h0008);
    rd(12'h020, 32'h0008_000C, "R5 bus error");
    @(negedge clk); cmplt = 16'h0010; term = 16'h0010;
    @(negedge clk); cmplt = '0; term = '0;
    @(negedge clk);
    chk({29'h0, err[4:2]}, 32'h3, "R6 err qualified");
    chk({31'h0, irq[4]}, 32'h1, "R7 irq on error flag");
    wr(12'h028, 32'h0000_0004);
    rd(12'h020, 32'h0008_0018, "R4 clear error ch2");

    // R8 freeze
    wr(12'h034, 32'h0000_0020);
    @(negedge clk);
    chk({16'h0, frz}, 32'h20, "R8 freeze set");
    wr(12'h038, 32'h0000_0020);
    @(negedge clk);
    chk({16'h0, frz}, 32'h0, "R8 freeze clear");

    // R9 reset request self-clear, ack wins
    wr(12'h034, 32'h0020_0000);
    repeat (3) @(negedge clk);
    chk({16'h0, crst}, 32'h20, "R9 request held");
    pulse(ack, 16'h0020);
    chk({16'h0, crst}, 32'h0, "R9 ack clears");
    @(negedge clk); req = 1; we = 1; addr = 12'h034; wdata = 32'h0040_0000; ack = 16'h0040;
    @(negedge clk); req = 0; we = 0; ack = '0;
    chk({16'h0, crst}, 32'h0, "R9 ack beats set");

    // R10 next command
    wr(12'h420, 32'hDEAD_BEE0);
    rd(12'h420, 32'hDEAD_BEE0, "R10 ch7 readback");
    chk(nxt[7*32 +: 32], 32'hDEAD_BEE0, "R10 ch7 output");
    rd(12'h110, 32'h0, "R10 ch0 untouched");

    // R11 semaphore
    wr(12'h7D0, 32'h2);
    rd(12'h7D0, 32'h2, "R11 add");
    chk({31'h0, run[15]}, 32'h1, "R11 run");
    pulse(dec, 16'h8000);
    rd(12'h7D0, 32'h1, "R11 dec");
    @(negedge clk); req = 1; we = 1; addr = 12'h7D0; wdata = 32'h1; dec = 16'h8000;
    @(negedge clk); req = 0; we = 0; dec = '0;
    rd(12'h7D0, 32'h1, "R11 add and dec");
    pulse(dec, 16'h8000);
    pulse(dec, 16'h8000);
    rd(12'h7D0, 32'h0, "R11 floor at zero");
    chk({31'h0, run[15]}, 32'h0, "R11 run low");

    // R12 read-only windows
    wr(12'h280, 32'h0);
    rd(12'h280, 32'h8000_1234, "R12 bar");
    wr(12'h2A0, 32'hF);
    rd(12'h2A0, 32'h8, "R12 debug");

    // R13 event beats same-cycle clear
    @(negedge clk); req = 1; we = 1; addr = 12'h018; wdata = 32'h40; cmplt = 16'h0040;
    @(negedge clk); req = 0; we = 0; cmplt = '0;
    rd(12'h010, 32'h0001_0052, "R13 event wins");

    // R4 base overwrite
    wr(12'h010, 32'h0);
    rd(12'h010, 32'h0, "R4 overwrite");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule